// File: doc/BRIEF.md
# Interleaved Channel Subset Selector

This block sits on a time-multiplexed sample stream in which every valid beat belongs to one of `NUM_CH` channels, always sent in the same rotating order. A cycle where the valid strobe is low marks the frame boundary. The block does not receive a channel number. It works out which channel a beat belongs to by counting valid beats since the last boundary. A per-channel keep mask picks the channels that pass. The output is a gated stream that carries only the selected samples, plus a trigger marker that lines up with the input frame boundaries.

The keep mask is captured at each boundary, so a frame is always filtered by a single mask value. A parameter sets which end of the mask vector refers to channel 0. The block also watches frame length. A frame that closes with a number of beats other than `NUM_CH` raises a one-cycle error pulse, and any beats past the last channel are dropped. All outputs come from registers and have one cycle of latency.

Top module: `chan_subset_sel`

## Requirements
- R1: With `CH0_AT_LSB` = 0, channel k is kept when `keep_mask[NUM_CH-1-k]` is 1, so the most significant bit stands for channel 0.
- R2: With `CH0_AT_LSB` = 1, channel k is kept when `keep_mask[k]` is 1.
- R3: Any cycle with `in_vld` low is a boundary. The k-th cycle with `in_vld` high after a boundary (counting from 0) carries channel k.
- R4: One cycle after a beat of a kept channel (k < `NUM_CH`), `out_gate` is 1 and `out_data` equals that beat's data. After every other cycle, `out_gate` is 0.
- R5: `out_trig` equals the inverse of `in_vld` from the previous cycle, and `out_vld` is always the inverse of `out_trig`.
- R6: The keep mask is sampled only on boundary cycles. A change in the middle of a frame has no effect until the next boundary.
- R7: `frame_err` is 1 for exactly one cycle, the cycle after a boundary, when at least one beat has arrived since the previous boundary and that beat count is not `NUM_CH`. It is 0 at all other times.
- R8: A boundary that directly follows another boundary (an idle gap) raises no error, and beats past index `NUM_CH-1` are never passed.
- R9: While reset is high and on the first cycle after it, `out_gate` = 0, `out_trig` = 1, `out_vld` = 0 and `frame_err` = 0. No beat passes and no error is raised until a boundary has been seen after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_data | input | DATA_W | Sample data of the current beat |
| in_vld | input | 1 | Beat valid; low marks a frame boundary |
| keep_mask | input | NUM_CH | Per-channel keep bits, ordered according to CH0_AT_LSB |
| out_data | output | DATA_W | Data of the most recently passed sample |
| out_gate | output | 1 | Selected sample present on out_data |
| out_trig | output | 1 | Delayed boundary marker |
| out_vld | output | 1 | Inverse of out_trig |
| frame_err | output | 1 | Pulse when a frame closed with the wrong beat count |

## Verification
The hardest case to reach is a frame with the wrong length that closes after tracking has synchronised. The error only fires when a boundary follows one or more beats whose count is not `NUM_CH`. Neither random masks nor well-formed frames produce that. The stimulus therefore mixes mostly well-formed frames with frames that are short, long or a single beat, and with idle gaps of several boundary cycles. It adds directed frames in which the mask changes mid-frame from all-zero to all-one, and a run of beats before the first boundary after reset. Two instances, one for each mask ordering, receive mirrored masks and must produce the same stream.

// File: rtl/chsel_pkg.sv
package chsel_pkg;

    typedef enum logic {
        TRK_UNSYNC = 1'b0,
        TRK_SYNC   = 1'b1
    } trk_state_e;

endpackage

// File: rtl/chsel_mask_order.sv
module chsel_mask_order #(
    parameter int NUM_CH     = 12,
    parameter bit CH0_AT_LSB = 1'b0
) (
    input  logic [NUM_CH-1:0] raw_mask,
    output logic [NUM_CH-1:0] ch_mask
);

    // ch_mask[k] always refers to channel k
    generate
        if (CH0_AT_LSB) begin : g_lsb
            assign ch_mask = raw_mask;
        end else begin : g_msb
            for (genvar k = 0; k < NUM_CH; k++) begin : g_rev
                assign ch_mask[k] = raw_mask[NUM_CH-1-k];
            end
        end
    endgenerate

endmodule

// File: rtl/chsel_pos_track.sv
module chsel_pos_track
    import chsel_pkg::*;
#(
    parameter int NUM_CH = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              beat_vld,
    input  logic [NUM_CH-1:0] ch_mask,
    output logic              pass,
    output logic              err_q
);

    localparam int IDX_W = $clog2(NUM_CH + 2);
    localparam logic [IDX_W-1:0] FULL_IDX = IDX_W'(NUM_CH);
    localparam logic [IDX_W-1:0] SAT_IDX  = IDX_W'(NUM_CH + 1);

    typedef struct packed {
        logic [IDX_W-1:0]  idx;
        logic [NUM_CH-1:0] mask;
        trk_state_e        st;
        logic              err;
    } trk_t;

    trk_t trk_d, trk_q;
    logic hit;

    always_comb begin
        trk_d = trk_q;
        hit   = 1'b0;
        pass  = 1'b0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (trk_q.idx == IDX_W'(i)) begin
                hit = trk_q.mask[i];
            end
        end
        if (!beat_vld) begin
            trk_d.idx  = '0;
            trk_d.mask = ch_mask;
            trk_d.st   = TRK_SYNC;
            trk_d.err  = (trk_q.st == TRK_SYNC) && (trk_q.idx != '0)
                         && (trk_q.idx != FULL_IDX);
        end else begin
            trk_d.err = 1'b0;
            pass      = (trk_q.st == TRK_SYNC) && hit;
            if (trk_q.idx != SAT_IDX) begin
                trk_d.idx = trk_q.idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            trk_q.idx  <= '0;
            trk_q.mask <= '0;
            trk_q.st   <= TRK_UNSYNC;
            trk_q.err  <= 1'b0;
        end else begin
            trk_q <= trk_d;
        end
    end

    assign err_q = trk_q.err;

    // R8
    idx_range_chk: assert property (@(posedge clk) disable iff (rst)
        trk_q.idx <= SAT_IDX);

    // R9
    unsync_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (trk_q.st == TRK_UNSYNC) |-> (!pass && !trk_q.err));

endmodule

// File: rtl/chsel_out_stage.sv
module chsel_out_stage #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pass,
    input  logic              bound,
    input  logic [DATA_W-1:0] data_in,
    output logic [DATA_W-1:0] data_q,
    output logic              gate_q,
    output logic              trig_q
);

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              gate;
        logic              trig;
    } ost_t;

    ost_t ost_d, ost_q;

    always_comb begin
        ost_d      = ost_q;
        ost_d.gate = pass;
        ost_d.trig = bound;
        if (pass) begin
            ost_d.data = data_in;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ost_q.data <= '0;
            ost_q.gate <= 1'b0;
            ost_q.trig <= 1'b1;
        end else begin
            ost_q <= ost_d;
        end
    end

    assign data_q = ost_q.data;
    assign gate_q = ost_q.gate;
    assign trig_q = ost_q.trig;

    // R4
    data_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !gate_q |=> (gate_q || $stable(data_q)));

endmodule

// File: rtl/chan_subset_sel.sv
module chan_subset_sel #(
    parameter int NUM_CH     = 12,
    parameter int DATA_W     = 16,
    parameter bit CH0_AT_LSB = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_vld,
    input  logic [NUM_CH-1:0] keep_mask,
    output logic [DATA_W-1:0] out_data,
    output logic              out_gate,
    output logic              out_trig,
    output logic              out_vld,
    output logic              frame_err
);

    logic [NUM_CH-1:0] ch_mask;
    logic              pass;

    chsel_mask_order #(
        .NUM_CH     (NUM_CH),
        .CH0_AT_LSB (CH0_AT_LSB)
    ) mask_order_i (
        .raw_mask (keep_mask),
        .ch_mask  (ch_mask)
    );

    chsel_pos_track #(
        .NUM_CH (NUM_CH)
    ) pos_track_i (
        .clk      (clk),
        .rst      (rst),
        .beat_vld (in_vld),
        .ch_mask  (ch_mask),
        .pass     (pass),
        .err_q    (frame_err)
    );

    chsel_out_stage #(
        .DATA_W (DATA_W)
    ) out_stage_i (
        .clk     (clk),
        .rst     (rst),
        .pass    (pass),
        .bound   (!in_vld),
        .data_in (in_data),
        .data_q  (out_data),
        .gate_q  (out_gate),
        .trig_q  (out_trig)
    );

    assign out_vld = !out_trig;

    // R5
    gate_trig_excl_chk: assert property (@(posedge clk) disable iff (rst)
        out_gate |-> !out_trig);

    // R5
    trig_follow_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (out_trig == $past(!in_vld)));

    // R7
    err_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        frame_err |=> !frame_err);

    // R7
    err_on_trig_chk: assert property (@(posedge clk) disable iff (rst)
        frame_err |-> out_trig);

endmodule

// File: tb/chan_subset_sel_tb_top.sv
`timescale 1ns / 1ps
module chan_subset_sel_tb_top;

    localparam int N  = 12;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [DW-1:0] in_data = '0;
    logic          in_vld = 1'b0;
    logic [N-1:0]  mask_a = '0;
    logic [N-1:0]  mask_b = '0;

    logic [DW-1:0] data_a, data_b;
    logic          gate_a, gate_b, trig_a, trig_b, vld_a, vld_b, err_a, err_b;

    int checks = 0;
    int failures = 0;

    int           m_idx = 0;
    logic [N-1:0] m_mask = '0;
    bit           m_sync = 1'b0;
    logic          exp_gate = 1'b0;
    logic          exp_trig = 1'b1;
    logic          exp_err = 1'b0;
    logic [DW-1:0] exp_data = '0;

    always #2.5 clk = !clk;

    chan_subset_sel #(.NUM_CH(N), .DATA_W(DW), .CH0_AT_LSB(1'b0)) dut_i (
        .clk(clk), .rst(rst), .in_data(in_data), .in_vld(in_vld),
        .keep_mask(mask_a), .out_data(data_a), .out_gate(gate_a),
        .out_trig(trig_a), .out_vld(vld_a), .frame_err(err_a));

    chan_subset_sel #(.NUM_CH(N), .DATA_W(DW), .CH0_AT_LSB(1'b1)) dut_lsb_i (
        .clk(clk), .rst(rst), .in_data(in_data), .in_vld(in_vld),
        .keep_mask(mask_b), .out_data(data_b), .out_gate(gate_b),
        .out_trig(trig_b), .out_vld(vld_b), .frame_err(err_b));

    function automatic logic kept(logic [N-1:0] m, int idx);
        if (idx >= N) return 1'b0;
        return m[idx];
    endfunction

    function automatic logic bad_len(int idx, bit synced);
        return synced && (idx != 0) && (idx != N);
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic check_all();
        chk("R1 R4 gate (msb order)", 32'(gate_a), 32'(exp_gate));
        chk("R2 R4 gate (lsb order)", 32'(gate_b), 32'(exp_gate));
        if (exp_gate) begin
            chk("R1 R3 data (msb order)", 32'(data_a), 32'(exp_data));
            chk("R2 R3 data (lsb order)", 32'(data_b), 32'(exp_data));
        end
        chk("R5 trig", 32'(trig_a), 32'(exp_trig));
        chk("R5 trig lsb", 32'(trig_b), 32'(exp_trig));
        chk("R5 vld", 32'(vld_a), 32'(!exp_trig));
        chk("R7 err", 32'(err_a), 32'(exp_err));
        chk("R7 err lsb", 32'(err_b), 32'(exp_err));
    endtask

    // chm: channel-ordered keep vector (bit k = channel k)
    task automatic step(bit v, logic [DW-1:0] d, logic [N-1:0] chm);
        in_vld = v;
        in_data = d;
        mask_b = chm;
        for (int k = 0; k < N; k++) mask_a[N-1-k] = chm[k];
        exp_trig = !v;
        exp_err  = !v && bad_len(m_idx, m_sync);
        exp_gate = v && m_sync && kept(m_mask, m_idx);
        if (exp_gate) exp_data = d;
        if (!v) begin
            m_idx = 0;
            m_mask = chm;   // R6: mask captured only here
            m_sync = 1'b1;
        end else if (m_idx < N + 1) begin
            m_idx++;
        end
        @(negedge clk);
        check_all();
    endtask

    task automatic frame(int nb, logic [N-1:0] chm, int chg_at, logic [N-1:0] chm2);
        step(1'b0, DW'($urandom), chm);
        for (int b = 0; b < nb; b++) begin
            step(1'b1, DW'($urandom), (b >= chg_at) ? chm2 : chm);
        end
    endtask

    initial begin
        #(5.0 * 50000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'h1f2e3d4c));
        // R9 reset state
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk("R9 reset gate", 32'(gate_a), 32'd0);
            chk("R9 reset trig", 32'(trig_a), 32'd1);
            chk("R9 reset vld", 32'(vld_a), 32'd0);
            chk("R9 reset err", 32'(err_a), 32'd0);
        end
        rst = 1'b0;
        // R9 beats before first boundary: nothing passes, no error at boundary
        for (int i = 0; i < N + 3; i++) step(1'b1, DW'($urandom), '1);
        // directed frames
        frame(N, '1, N, '1);                          // R3 R4 all kept
        frame(N, N'(1), N, '0);                       // R1 R2 channel 0 only
        frame(N, N'(1) << (N - 1), N, '0);            // last channel only
        frame(N, '0, 3, '1);                          // R6 mid-frame change ignored
        frame(N, '1, 5, '0);                          // R6 new mask from next frame
        frame(N - 1, 12'h5a5, N, '0);                 // R7 short frame
        frame(N + 2, '1, N + 2, '1);                  // R7 R8 long frame, extra beats dropped
        frame(N, 12'h0f0, N, '0);
        step(1'b0, '0, '1);                           // R8 idle gap: no error
        step(1'b0, '0, '1);
        frame(1, '1, 1, '1);                          // R7 one-beat frame
        frame(N, '1, N, '1);
        // constrained random
        for (int f = 0; f < 300; f++) begin
            int r;
            int nb;
            r = int'($urandom % 100);
            nb = (r < 75) ? N : int'($urandom % (N + 4));
            frame(nb, N'($urandom), int'($urandom % (N + 1)), N'($urandom));
            for (int g = 0; g < int'($urandom % 3); g++) step(1'b0, '0, N'($urandom));
        end
        step(1'b0, '0, '0);
        step(1'b0, '0, '0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule